// File: doc/BRIEF.md
# Chip-Select Qualifier

This block decides, once per bus cycle, whether a single programmable chip select fires. A separate comparator reports whether the address falls in the select's range. This block adds the rest of the decision. It checks that the cycle type is in the configured address space. For ordinary data cycles it applies a byte-lane rule that depends on the configured port width, address bit 0 and the size bit. For interrupt-acknowledge cycles it compares the acknowledged level with a programmed priority level, and it can raise an autovector request that ends the acknowledge cycle without an external vector.

The attributes are sampled on a one-cycle cycle-start strobe. Both outputs are registered and hold through the bus cycle. They drop on the end-of-cycle strobe.

Top module: `cs_qualify`

## Requirements
- R1: While reset is high, and in the first cycle after it, both `cs_o` and `avec_o` are 0.
- R2: Outputs are loaded on the clock edge where `cyc_start` is 1. They hold while `cyc_start` and `cyc_end` are both 0, even if the inputs change. They clear on the edge where `cyc_end` is 1 and `cyc_start` is 0. When both strobes are 1 on the same edge, the new cycle is loaded.
- R3: `cyc_kind` encodes 00 = interrupt acknowledge, 01 = user data, 10 = supervisor data, 11 = reserved. `cfg_space` encodes 00 = CPU space (acknowledge cycles only), 01 = user only, 10 = supervisor only, 11 = user or supervisor. The reserved kind never matches. `cs_o` asserts only if the space matches and `range_hit` is 1.
- R4: With `cfg_port16` = 0 (8-bit port), `cfg_lane` values 01, 10 and 11 all permit a data-cycle assertion, whatever the values of `addr0` and `size0`.
- R5: With `cfg_port16` = 1 and `cfg_lane` = 11 (both bytes), a data cycle asserts for every `addr0`/`size0` combination.
- R6: With `cfg_port16` = 1 and `cfg_lane` = 10 (upper byte), a data cycle asserts only when `addr0` = 0.
- R7: With `cfg_port16` = 1 and `cfg_lane` = 01 (lower byte), a data cycle asserts when `addr0` = 1 or `size0` = 1. It does not assert for `addr0` = 0 with `size0` = 0.
- R8: `cfg_lane` = 00 never asserts a data cycle in either port width.
- R9: In CPU space, an acknowledge cycle qualifies when `cfg_level` = 000, or when `addr_lvl` equals `cfg_level`. The byte-lane field plays no part in this decision.
- R10: On a qualifying acknowledge cycle, `avec_o` equals `cfg_autovec`. `cs_o` asserts in both cases.
- R11: `avec_o` stays 0 on every data cycle, even with `cfg_autovec` = 1. `cfg_level` has no effect on data cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-cycle strobe; attributes valid |
| cyc_end | input | 1 | One-cycle end-of-cycle strobe |
| cyc_kind | input | 2 | Cycle type code |
| range_hit | input | 1 | Address-range hit from base comparator |
| addr0 | input | 1 | Address bit 0 |
| size0 | input | 1 | Size bit (1 = word) |
| addr_lvl | input | LVL_W | Address bits 3:1, acknowledged level |
| cfg_space | input | 2 | Space field |
| cfg_lane | input | 2 | Byte-lane field |
| cfg_level | input | LVL_W | Priority-level field |
| cfg_autovec | input | 1 | Autovector enable |
| cfg_port16 | input | 1 | 1 = 16-bit port, 0 = 8-bit port |
| cs_o | output | 1 | Registered chip-select strobe |
| avec_o | output | 1 | Registered autovector request |

## Verification
The hardest condition to reach is an acknowledge cycle in which the byte-lane field would block a data cycle while the level still matches. This shows that lane qualification is bypassed in CPU space. The stimulus sets lane 00 on acknowledge cycles at a matching level and at a mismatched level. It then runs data cycles with the autovector enable set, to show that the request never leaks out. Each cycle also changes its attributes after the start strobe and checks that the outputs hold. A separate cycle raises both strobes on the same edge.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    KIND_IACK = 2'b00,
    KIND_USER = 2'b01,
    KIND_SUPV = 2'b10,
    KIND_RSVD = 2'b11
  } kind_e;

  localparam logic [1:0] SP_CPU  = 2'b00;
  localparam logic [1:0] SP_USER = 2'b01;
  localparam logic [1:0] SP_SUPV = 2'b10;
  localparam logic [1:0] SP_DATA = 2'b11;

  localparam logic [1:0] LANE_NONE  = 2'b00;
  localparam logic [1:0] LANE_LOW   = 2'b01;
  localparam logic [1:0] LANE_HIGH  = 2'b10;
  localparam logic [1:0] LANE_BOTH  = 2'b11;
endpackage

// File: rtl/csq_lane_qual.sv
module csq_lane_qual
  import csq_pkg::*;
(
  input  logic [1:0] lane,
  input  logic       port16,
  input  logic       addr0,
  input  logic       size0,
  output logic       lane_ok
);
  always_comb begin
    unique case (lane)
      LANE_LOW:  lane_ok = port16 ? (addr0 | size0) : 1'b1;
      LANE_HIGH: lane_ok = port16 ? ~addr0 : 1'b1;
      LANE_BOTH: lane_ok = 1'b1;
      default:   lane_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/csq_level_match.sv
module csq_level_match #(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] cfg_level,
  input  logic [LVL_W-1:0] addr_lvl,
  output logic             lvl_ok
);
  localparam logic [LVL_W-1:0] ANY_LVL = '0;

  always_comb lvl_ok = (cfg_level == ANY_LVL) || (cfg_level == addr_lvl);
endmodule

// File: rtl/csq_space_match.sv
module csq_space_match
  import csq_pkg::*;
(
  input  logic [1:0] cfg_space,
  input  logic [1:0] kind,
  output logic       space_ok,
  output logic       is_iack
);
  kind_e k;
  always_comb begin
    k        = kind_e'(kind);
    is_iack  = (k == KIND_IACK);
    unique case (cfg_space)
      SP_CPU:  space_ok = (k == KIND_IACK);
      SP_USER: space_ok = (k == KIND_USER);
      SP_SUPV: space_ok = (k == KIND_SUPV);
      default: space_ok = (k == KIND_USER) || (k == KIND_SUPV);
    endcase
  end
endmodule

// File: rtl/cs_qualify.sv
module cs_qualify
  import csq_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  logic             cyc_end,
  input  logic [1:0]       cyc_kind,
  input  logic             range_hit,
  input  logic             addr0,
  input  logic             size0,
  input  logic [LVL_W-1:0] addr_lvl,
  input  logic [1:0]       cfg_space,
  input  logic [1:0]       cfg_lane,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic             cfg_autovec,
  input  logic             cfg_port16,
  output logic             cs_o,
  output logic             avec_o
);
  logic lane_ok, lvl_ok, space_ok, is_iack;
  logic qual_ok, cs_next, av_next;

  csq_lane_qual u_lane (
    .lane(cfg_lane), .port16(cfg_port16), .addr0(addr0), .size0(size0),
    .lane_ok(lane_ok)
  );

  csq_level_match #(.LVL_W(LVL_W)) u_lvl (
    .cfg_level(cfg_level), .addr_lvl(addr_lvl), .lvl_ok(lvl_ok)
  );

  csq_space_match u_space (
    .cfg_space(cfg_space), .kind(cyc_kind), .space_ok(space_ok), .is_iack(is_iack)
  );

  // CPU space qualifies on level, data spaces on byte lane
  always_comb begin
    qual_ok = is_iack ? lvl_ok : lane_ok;
    cs_next = range_hit & space_ok & qual_ok;
    av_next = cs_next & is_iack & cfg_autovec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_o   <= 1'b0;
      avec_o <= 1'b0;
    end else if (cyc_start) begin
      cs_o   <= cs_next;
      avec_o <= av_next;
    end else if (cyc_end) begin
      cs_o   <= 1'b0;
      avec_o <= 1'b0;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!cs_o && !avec_o));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!cyc_start && !cyc_end) |=> ($stable(cs_o) && $stable(avec_o)));

  p_end_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && !cyc_start) |=> (!cs_o && !avec_o));

  p_need_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !range_hit) |=> !cs_o);

  p_lane_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && cfg_lane == LANE_NONE && cyc_kind != KIND_IACK) |=> !cs_o);

  p_av_implies_cs_r10: assert property (@(posedge clk) disable iff (rst)
    avec_o |-> cs_o);

  p_no_av_data_r11: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && cyc_kind != KIND_IACK) |=> !avec_o);
endmodule

// File: tb/tb_cs_qualify.sv
module tb_cs_qualify;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 0, cyc_end = 0;
  logic [1:0] cyc_kind = 0;
  logic range_hit = 0, addr0 = 0, size0 = 0;
  logic [2:0] addr_lvl = 0;
  logic [1:0] cfg_space = 0, cfg_lane = 0;
  logic [2:0] cfg_level = 0;
  logic cfg_autovec = 0, cfg_port16 = 0;
  logic cs_o, avec_o;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  cs_qualify #(.LVL_W(3)) dut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_end(cyc_end),
    .cyc_kind(cyc_kind), .range_hit(range_hit), .addr0(addr0), .size0(size0),
    .addr_lvl(addr_lvl), .cfg_space(cfg_space), .cfg_lane(cfg_lane),
    .cfg_level(cfg_level), .cfg_autovec(cfg_autovec), .cfg_port16(cfg_port16),
    .cs_o(cs_o), .avec_o(avec_o)
  );

  task automatic check(input string req, input logic ecs, input logic eav);
    n_run++;
    if (cs_o !== ecs || avec_o !== eav) begin
      n_fail++;
      $display("FAIL %s: cs=%b av=%b expected cs=%b av=%b", req, cs_o, avec_o, ecs, eav);
    end
  endtask

  // one full bus cycle: start, hold with disturbed inputs, end
  task automatic cyc(input logic [1:0] kind, input logic hit, input logic a0,
                     input logic sz, input logic [2:0] al, input logic [1:0] sp,
                     input logic [1:0] ln, input logic [2:0] lv, input logic av,
                     input logic p16, input logic ecs, input logic eav,
                     input string req);
    @(negedge clk);
    cyc_kind = kind; range_hit = hit; addr0 = a0; size0 = sz; addr_lvl = al;
    cfg_space = sp; cfg_lane = ln; cfg_level = lv; cfg_autovec = av;
    cfg_port16 = p16; cyc_start = 1;
    @(negedge clk);
    cyc_start = 0;
    check(req, ecs, eav);
    addr0 = ~a0; range_hit = ~hit; cyc_kind = ~kind;
    @(negedge clk);
    check({req, " hold R2"}, ecs, eav);
    cyc_end = 1;
    @(negedge clk);
    cyc_end = 0;
    check({req, " end R2"}, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 0);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", 0, 0);
  endtask

  task automatic t_port8;
    for (int l = 1; l < 4; l++)
      for (int c = 0; c < 4; c++)
        cyc(2'b01, 1, c[0], c[1], 0, 2'b01, 2'(l), 0, 0, 0, 1, 0, "R4 8-bit lane");
  endtask

  task automatic t_both;
    for (int c = 0; c < 4; c++)
      cyc(2'b10, 1, c[0], c[1], 0, 2'b10, 2'b11, 0, 0, 1, 1, 0, "R5 both");
  endtask

  task automatic t_upper;
    for (int c = 0; c < 4; c++)
      cyc(2'b01, 1, c[0], c[1], 0, 2'b11, 2'b10, 0, 0, 1, !c[0], 0, "R6 upper");
  endtask

  task automatic t_lower;
    for (int c = 0; c < 4; c++)
      cyc(2'b10, 1, c[0], c[1], 0, 2'b11, 2'b01, 0, 0, 1, c[0] | c[1], 0, "R7 lower");
  endtask

  task automatic t_lane_zero;
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 4; c++)
        cyc(2'b01, 1, c[0], c[1], 0, 2'b01, 2'b00, 0, 0, p[0], 0, 0, "R8 lane 00");
  endtask

  task automatic t_space;
    cyc(2'b01, 1, 0, 1, 0, 2'b10, 2'b11, 0, 0, 1, 0, 0, "R3 user vs supv");
    cyc(2'b10, 1, 0, 1, 0, 2'b01, 2'b11, 0, 0, 1, 0, 0, "R3 supv vs user");
    cyc(2'b11, 1, 0, 1, 0, 2'b11, 2'b11, 0, 0, 1, 0, 0, "R3 reserved");
    cyc(2'b10, 1, 0, 1, 0, 2'b11, 2'b11, 0, 0, 1, 1, 0, "R3 data any");
    cyc(2'b01, 0, 0, 1, 0, 2'b01, 2'b11, 0, 0, 1, 0, 0, "R3 no hit");
    cyc(2'b00, 1, 0, 1, 3, 2'b01, 2'b11, 3, 1, 1, 0, 0, "R3 iack in user");
    cyc(2'b01, 1, 0, 1, 3, 2'b00, 2'b11, 3, 1, 1, 0, 0, "R3 data in cpu");
  endtask

  task automatic t_level;
    for (int a = 0; a < 8; a++)
      cyc(2'b00, 1, 0, 0, 3'(a), 2'b00, 2'b00, 0, 0, 1, 1, 0, "R9 any level");
    for (int a = 0; a < 8; a++)
      cyc(2'b00, 1, 0, 0, 3'(a), 2'b00, 2'b00, 5, 0, 1, a == 5, 0, "R9 level 5");
    cyc(2'b00, 0, 0, 0, 5, 2'b00, 2'b11, 5, 1, 1, 0, 0, "R9 R3 iack no hit");
  endtask

  task automatic t_autovec;
    cyc(2'b00, 1, 0, 0, 7, 2'b00, 2'b00, 7, 1, 1, 1, 1, "R10 autovector on");
    cyc(2'b00, 1, 0, 0, 2, 2'b00, 2'b10, 0, 1, 0, 1, 1, "R10 any level av");
    cyc(2'b00, 1, 0, 0, 7, 2'b00, 2'b11, 7, 0, 1, 1, 0, "R10 autovector off");
    cyc(2'b00, 1, 0, 0, 6, 2'b00, 2'b11, 7, 1, 1, 0, 0, "R10 mismatch no av");
  endtask

  task automatic t_data_av;
    cyc(2'b01, 1, 1, 1, 4, 2'b01, 2'b11, 4, 1, 1, 1, 0, "R11 user av off");
    cyc(2'b10, 1, 0, 1, 2, 2'b10, 2'b11, 5, 1, 1, 1, 0, "R11 level ignored");
    cyc(2'b10, 1, 0, 0, 2, 2'b11, 2'b10, 6, 1, 0, 1, 0, "R11 8-bit av off");
  endtask

  task automatic t_both_strobes;
    cyc(2'b01, 1, 0, 1, 0, 2'b01, 2'b11, 0, 0, 1, 1, 0, "R2 setup");
    @(negedge clk);
    cyc_kind = 2'b00; cfg_space = 2'b00; cfg_level = 0; cfg_autovec = 1;
    range_hit = 1; cyc_start = 1;
    @(negedge clk);
    cyc_start = 0;
    check("R2 first load", 1, 1);
    cyc_start = 1; cyc_end = 1; cyc_kind = 2'b01;
    @(negedge clk);
    cyc_start = 0; cyc_end = 0;
    check("R2 start beats end", 0, 0);
    cyc_kind = 2'b00; cyc_start = 1;
    @(negedge clk);
    cyc_start = 0; cyc_end = 1;
    check("R2 reload", 1, 1);
    @(negedge clk);
    cyc_end = 0;
    check("R2 cleared", 0, 0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog R2: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_port8();
    t_both();
    t_upper();
    t_lower();
    t_lane_zero();
    t_space();
    t_level();
    t_autovec();
    t_data_av();
    t_both_strobes();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule